// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a serial voltage-output DAC. A host writes 16-bit frames over three wires: an active-low frame select, a serial clock and serial data. All three pins are resampled by a fast system clock through a synchroniser chain, and edges are detected in the system domain. Bits are taken most significant first on each falling serial-clock edge while the frame select is low.

The sixteenth falling edge of a frame commits it. The two top bits set the operating mode. These are normal drive, or one of three power-down output states. A normal-mode frame also loads a left-aligned DAC code of 8, 10 or 12 bits. A frame select that rises early discards the partial frame. The block produces the code register, the mode bits, a power-down flag and a one-cycle commit strobe that drive the analog string, the amplifier enable and the output load switches.

Top module: `dac_serial_front`

## Requirements
- R1: After reset the code register is zero, the mode is normal (00), the power-down flag is low and the commit strobe is low.
- R2: While frame_n is low, ser_dat is taken on each falling ser_clk edge, first bit as frame bit 15. On the sixteenth such edge of a normal-mode frame, dac_code loads frame bits 13 down to 14-RES (13:2 for RES=12). The frame bits below that field have no effect.
- R3: At the same commit, pwr_mode loads frame bits 15:14 (00 normal, 01 output to ground through 1k, 10 output to ground through 100k, 11 output three-stated). pwr_down is high exactly when pwr_mode is not 00.
- R4: upd_stb is high for exactly one cycle per committed frame, in the cycle the new register values first appear. With two synchroniser stages, this is the third system clock edge after the falling ser_clk edge at the pin.
- R5: If frame_n rises before the sixteenth falling edge, code, mode and strobe do not change. The next frame counts its bits from zero.
- R6: Falling ser_clk edges after the sixteenth one in the same low period of frame_n are ignored. Only a new falling edge of frame_n starts another frame.
- R7: Falling ser_clk edges while frame_n is high change nothing.
- R8: If the sixteenth falling edge and the rise of frame_n are detected in the same system cycle, the frame commits.
- R9: A frame whose mode bits are non-zero leaves dac_code unchanged, so the stored code survives entry into and exit from power-down.
- R10: The code width follows RES. With RES=8, dac_code takes frame bits 13:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial clock; data taken on its falling edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| dac_code | output | RES | Stored DAC code |
| pwr_mode | output | 2 | Operating mode: 00 run, 01 1k, 10 100k, 11 high-Z |
| pwr_down | output | 1 | High in any of the three power-down modes |
| upd_stb | output | 1 | One-cycle pulse when a frame is committed |

## Verification
The commit on the sixteenth falling serial-clock edge and the end-of-frame detection on the rising frame select can land in the same system cycle. In that case the frame commits rather than aborts. The bench provokes this by changing ser_clk low and frame_n high at the same instant, so both travel through identical synchroniser depth. The cycle-accurate reference model expects the commit three edges later. The case where the rise comes one bit early is judged against the abort path, where the code, mode and strobe must stay flat.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int FRAME_BITS = 16;
  localparam int MODE_MSB   = 15;
  localparam int CODE_MSB   = 13;

  typedef enum logic [1:0] {
    PM_RUN      = 2'b00,
    PM_GND_1K   = 2'b01,
    PM_GND_100K = 2'b10,
    PM_HIZ      = 2'b11
  } pmode_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = STAGES * W;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CW-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
  parameter bit FALLING = 1'b1,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= cur;
  end

  generate
    if (FALLING) begin : g_fall
      assign hit = prev_q & ~cur;
    end else begin : g_rise
      assign hit = ~prev_q & cur;
    end
  endgenerate
endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx
  import dacfe_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frm_fall,
  input  logic           frm_rise,
  input  logic           sck_fall,
  input  logic           sdat,
  output logic           done,
  output logic [1:0]     mode_f,
  output logic [RES-1:0] code_f
);
  localparam int CNT_W    = $clog2(FRAME_BITS);
  localparam int SH_W     = FRAME_BITS - 1;
  localparam int CODE_LSB = CODE_MSB - RES + 1;

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [FRAME_BITS-1:0] word;
  logic take, last_bit;

  assign word     = {sh_q, sdat};
  assign take     = armed_q & sck_fall;
  assign last_bit = (cnt_q == CNT_W'(FRAME_BITS - 1));
  assign done     = take & last_bit;
  assign mode_f   = word[MODE_MSB -: 2];
  assign code_f   = word[CODE_MSB:CODE_LSB];

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    if (frm_fall) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (take) begin
      sh_d  = word[SH_W-1:0];
      cnt_d = cnt_q + CNT_W'(1);
      if (last_bit) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end
    end
    if (frm_rise) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      sh_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
#(
  parameter int RES         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  output logic [RES-1:0] dac_code,
  output logic [1:0]     pwr_mode,
  output logic           pwr_down,
  output logic           upd_stb
);
  logic rst_meta_q, rst_int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_q  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_q  <= rst_meta_q;
    end
  end

  logic [2:0] pins_s;
  logic frm_s, sck_s, dat_s;

  dacfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_q),
    .d     ({frame_n, ser_clk, ser_dat}),
    .q     (pins_s)
  );
  assign {frm_s, sck_s, dat_s} = pins_s;

  logic frm_fall, frm_rise, sck_fall;

  dacfe_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_frm_fall (
    .clk(clk), .rst_n(rst_int_q), .cur(frm_s), .hit(frm_fall));
  dacfe_edge #(.FALLING(1'b0), .RST_VAL(1'b1)) u_frm_rise (
    .clk(clk), .rst_n(rst_int_q), .cur(frm_s), .hit(frm_rise));
  dacfe_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_sck_fall (
    .clk(clk), .rst_n(rst_int_q), .cur(sck_s), .hit(sck_fall));

  logic           f_done;
  logic [1:0]     f_mode;
  logic [RES-1:0] f_code;

  dacfe_frame_rx #(.RES(RES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_q),
    .frm_fall (frm_fall),
    .frm_rise (frm_rise),
    .sck_fall (sck_fall),
    .sdat     (dat_s),
    .done     (f_done),
    .mode_f   (f_mode),
    .code_f   (f_code)
  );

  pmode_e         mode_q, mode_d;
  logic [RES-1:0] code_q, code_d;
  logic           pd_q, pd_d, stb_q, code_en;

  always_comb begin
    mode_d  = pmode_e'(f_mode);
    code_d  = f_code;
    pd_d    = (mode_d != PM_RUN);
    code_en = f_done && (mode_d == PM_RUN);
  end

  always_ff @(posedge clk or negedge rst_int_q) begin
    if (!rst_int_q) begin
      code_q <= '0;
      mode_q <= PM_RUN;
      pd_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= f_done;
      if (code_en) code_q <= code_d;
      if (f_done) begin
        mode_q <= mode_d;
        pd_q   <= pd_d;
      end
    end
  end

  assign dac_code = code_q;
  assign pwr_mode = mode_q;
  assign pwr_down = pd_q;
  assign upd_stb  = stb_q;
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_clk,
  input logic [CW-1:0] dac_code,
  input logic [1:0]    pwr_mode,
  input logic          pwr_down,
  input logic          upd_stb
);
  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  assert_stb_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> !$past(ser_clk, 3));

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(dac_code));

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(pwr_mode));

  assert_pd_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down == (pwr_mode != 2'b00));

  assert_pd_keeps_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && pwr_mode != 2'b00) |-> $stable(dac_code));
endmodule

bind dac_serial_front dac_serial_front_chk #(.CW(RES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_clk  (ser_clk),
  .dac_code (dac_code),
  .pwr_mode (pwr_mode),
  .pwr_down (pwr_down),
  .upd_stb  (upd_stb)
);

// File: tb/dac_serial_front_test.sv
`timescale 1ns/1ps
module dac_serial_front_test;
  logic clk = 1'b0;
  logic rst_n, frame_n, ser_clk, ser_dat;
  logic [11:0] code12;
  logic [7:0]  code8;
  logic [1:0]  mode12, mode8;
  logic pd12, pd8, stb12, stb8;

  always #4 clk = ~clk;

  dac_serial_front #(.RES(12)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dac_code(code12), .pwr_mode(mode12), .pwr_down(pd12), .upd_stb(stb12));

  dac_serial_front #(.RES(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dac_code(code8), .pwr_mode(mode8), .pwr_down(pd8), .upd_stb(stb8));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int n_stb = 0;
  bit run_cmp = 1'b0;

  // reference model state
  int q_cyc[$];
  int q_word[$];
  int exp_c12 = 0, exp_c8 = 0, exp_mode = 0, exp_stb = 0;
  bit m_armed = 1'b0;
  int m_cnt = 0;
  int m_word = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    exp_stb = 0;
    if (!rst_n) begin
      exp_c12 = 0; exp_c8 = 0; exp_mode = 0;
    end else if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      int w;
      w = q_word.pop_front();
      void'(q_cyc.pop_front());
      exp_stb  = 1;
      exp_mode = (w >> 14) & 3;
      if (exp_mode == 0) begin
        exp_c12 = (w >> 2) & 12'hFFF;
        exp_c8  = (w >> 6) & 8'hFF;
      end
    end
  end

  always @(negedge clk) begin
    if (stb12) n_stb++;
    if (rst_n && run_cmp) begin
      check(code12 == exp_c12[11:0], "R2 code12", code12, exp_c12);
      check(code8 == exp_c8[7:0], "R10 code8", code8, exp_c8);
      check(mode12 == exp_mode[1:0] && mode8 == exp_mode[1:0], "R3 mode", mode12, exp_mode);
      check(pd12 == (exp_mode != 0), "R3 pwr_down", pd12, exp_mode != 0);
      check(stb12 == exp_stb[0] && stb8 == exp_stb[0], "R4 strobe", stb12, exp_stb);
    end
  end

  task automatic frame_low();
    frame_n = 1'b0;
    m_armed = 1'b1; m_cnt = 0; m_word = 0;
  endtask

  task automatic frame_high();
    frame_n = 1'b1;
    m_armed = 1'b0;
  endtask

  task automatic drive_bit(input bit b, input bit tie_rise);
    ser_dat = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
    if (m_armed) begin
      m_word = ((m_word << 1) | int'(b)) & 16'hFFFF;
      m_cnt++;
      if (m_cnt == 16) begin
        q_cyc.push_back(cyc + 3);
        q_word.push_back(m_word);
        m_armed = 1'b0;
      end
    end
    if (tie_rise) frame_high();
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra, input bit tie);
    frame_low();
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) drive_bit(w[15-i], tie && (i == nbits - 1));
    for (int j = 0; j < extra; j++) drive_bit(~w[j], 1'b0);
    if (!tie) begin
      repeat (2) @(negedge clk);
      frame_high();
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 100000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; ser_clk = 1'b1; ser_dat = 1'b0;
    repeat (3) @(negedge clk);
    check(code12 == 0 && code8 == 0, "R1 reset code", code12, 0);
    check(mode12 == 0 && pd12 == 0 && stb12 == 0, "R1 reset mode/pd/stb",
          {mode12, pd12, stb12}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(code12 == 0 && mode12 == 0 && pd12 == 0, "R1 after release", code12, 0);
    run_cmp = 1'b1;

    // R2/R10: normal frames, low bits don't care
    send(16'h2AF3, 16, 0, 1'b0);
    check(code12 == 12'hABC, "R2 first frame", code12, 12'hABC);
    check(code8 == 8'hAB, "R10 8-bit field", code8, 8'hAB);
    send(16'h1694, 16, 0, 1'b0);
    check(code12 == 12'h5A5, "R2 second frame", code12, 12'h5A5);

    // R3/R9: power-down modes keep the code
    send(16'h7FFC, 16, 0, 1'b0);
    check(mode12 == 2'b01 && pd12, "R3 mode 1k", mode12, 1);
    check(code12 == 12'h5A5, "R9 code kept in 1k", code12, 12'h5A5);
    send(16'hC48C, 16, 0, 1'b0);
    check(mode12 == 2'b11 && pd12, "R3 mode hiz", mode12, 3);
    send(16'h8004, 16, 0, 1'b0);
    check(mode12 == 2'b10 && code12 == 12'h5A5, "R9 code kept in 100k", code12, 12'h5A5);
    send(16'h3FFD, 16, 0, 1'b0);
    check(mode12 == 2'b00 && !pd12 && code12 == 12'hFFF, "R3 back to run", code12, 12'hFFF);

    // R5: abort after 15 bits, then a clean frame counts from zero
    send(16'h0004, 15, 0, 1'b0);
    check(code12 == 12'hFFF, "R5 aborted frame ignored", code12, 12'hFFF);
    send(16'h0008, 16, 0, 1'b0);
    check(code12 == 12'h002, "R5 restart from zero", code12, 12'h002);

    // R6: extra clocks after the 16th while frame_n stays low
    send(16'h0010, 16, 5, 1'b0);
    check(code12 == 12'h004, "R6 extra edges ignored", code12, 12'h004);

    // R7: clocks with frame_n high
    for (int k = 0; k < 20; k++) drive_bit(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    check(code12 == 12'h004 && mode12 == 0, "R7 idle clocks ignored", code12, 12'h004);

    // R8: 16th fall and frame rise together
    send(16'h1FFC, 16, 0, 1'b1);
    check(code12 == 12'h7FF, "R8 tie commits", code12, 12'h7FF);

    // R4: one strobe per committed frame (9 frames)
    check(n_stb == 9, "R4 strobe count", n_stb, 9);
    check(q_cyc.size() == 0, "R4 model queue drained", q_cyc.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule